// File: doc/BRIEF.md
# Card Data-Line Error Checker

This block watches the single data line of a memory card interface while block transfers run, and reports the three data-phase error classes as one-cycle pulses: a CRC error, an end-bit error and a timeout. It does not drive the line. The controller that owns the transfer tells it which phase comes next, and then hands it every sampled line bit as it arrives.

A request is taken only while the checker is idle. It carries one of three modes. In read mode the checker waits for a start bit, then takes the data block and computes a CRC16 over it. It then compares that value with the 16 CRC bits that follow, and checks the closing end bit. In write mode it waits for the card's CRC status token and checks the token's three bits and its end bit. After that it times the busy period, during which the card holds the line low. Busy-only mode times a busy period on its own, as after a response that signals busy. Every waiting phase and every busy phase has its own timeout. The counter restarts at the start of each phase and counts line strobes. When the checker reports any error, it drops the transfer and goes back to idle.

The sampled bits arrive as a stream qualified by `bit_vld`. The stream has no ready signal: the card sets the pace of the line, so the checker must accept a bit in every cycle where `bit_vld` is high and has no way to apply back-pressure. A bit is consumed in the cycle it is valid. Cycles without `bit_vld` change nothing, and a bit sent in the same cycle as an accepted request is ignored.

Top module: `dline_err_chk`

## Requirements
- R1: After reset all three error outputs are low and the checker is idle. While idle, line bits produce no error pulse.
- R2: A read frame raises no error. The frame is a 0 start bit, then `blk_len`×8 data bits MSB first, then 16 CRC bits MSB first, then an end bit of 1. The CRC bits are the CRC16 of the data with polynomial 0x1021 and initial value 0. A `blk_len` of 0 means 2^LEN_W bytes.
- R3: In a read, if the received CRC differs from the computed one, one `err_crc` pulse appears in the cycle after the strobe of the last CRC bit.
- R4: In a read with a correct CRC, an end bit of 0 raises one `err_endbit` pulse.
- R5: In a write, the status token is a 0 start bit, three token bits sent first-bit-first, and an end bit. If the end bit is 1 and the token is not 010, one `err_crc` pulse is raised.
- R6: In a write, a status end bit of 0 raises one `err_endbit` pulse, and this takes precedence over the token check.
- R7: In a write, a 010 token with an end bit of 1 starts busy. Busy ends with no error at the first strobe where the line is high.
- R8: In a read, if `to_limit` strobes arrive with the line high before the start bit, one `err_timeout` pulse is raised. The same wait with one strobe fewer passes.
- R9: In a write, if `to_limit` strobes arrive with the line high before the status start bit, one `err_timeout` pulse is raised.
- R10: If `to_limit` consecutive strobes arrive with the line low during busy, one `err_timeout` pulse is raised. The counter restarts when busy begins, so strobes counted while waiting for the token do not carry over.
- R11: Busy-only mode (`xfer_mode` = 2) begins directly in busy. It ends cleanly on a high strobe, or times out as in R10. `xfer_mode` 0 is read and 1 is write. Value 3 is not accepted.
- R12: After any error the checker is idle, and it ignores line bits until the next accepted request.
- R13: Each error output is high for single cycles only, and at most one error output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Request to check a new phase, accepted while idle |
| xfer_mode | input | 2 | 0 read, 1 write status and busy, 2 busy only |
| blk_len | input | LEN_W | Read block length in bytes, 0 meaning 2^LEN_W |
| to_limit | input | TO_W | Timeout limit in line strobes |
| bit_vld | input | 1 | Strobe: `bit_in` holds a sampled line bit |
| bit_in | input | 1 | Sampled data-line level |
| err_crc | output | 1 | CRC16 mismatch or bad status token pulse |
| err_endbit | output | 1 | End bit sampled as 0 pulse |
| err_timeout | output | 1 | Start, status or busy timeout pulse |

## Verification
The hardest situation to reach from the ports is the write sequence where the CRC status token arrives late but still inside the limit, and is then followed by a busy period just short of the limit. This is the only case in which a timer that fails to restart at the new phase would fire. The stimulus waits `to_limit`−1 high strobes before the token, then holds the line low for `to_limit`−1 strobes, and then expects no pulse. A second sequence sends a corrupted CRC followed by a zero end bit. It shows that the abort suppresses the later end-bit error, so exactly one pulse appears.

// File: rtl/dle_pkg.sv
package dle_pkg;

  typedef enum logic [1:0] {
    XM_READ  = 2'd0,
    XM_WRITE = 2'd1,
    XM_BUSY  = 2'd2
  } xfer_mode_e;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_RD_WAIT = 4'd1,
    S_RD_DATA = 4'd2,
    S_RD_CRC  = 4'd3,
    S_RD_END  = 4'd4,
    S_WR_WAIT = 4'd5,
    S_WR_TOK  = 4'd6,
    S_WR_END  = 4'd7,
    S_BUSY    = 4'd8
  } dle_state_e;

  localparam int TOK_W = 3;
  localparam logic [TOK_W-1:0] TOK_GOOD = 3'b010;

endpackage

// File: rtl/dle_crc_ser.sv
// Bit-serial CRC, MSB-first, polynomial chosen by parameter.
module dle_crc_ser #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic         fb;
  logic [W-1:0] nxt;

  assign fb = din ^ crc[W-1];

  generate
    for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
        assign nxt[i] = fb & POLY[i];
      end else begin : g_up
        assign nxt[i] = crc[i-1] ^ (fb & POLY[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
  end

endmodule

// File: rtl/dle_shreg.sv
// Serial-in shift register for received CRC and token bits.
module dle_shreg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/dle_phase_tmr.sv
// Strobe counter for one waiting phase; expire is combinational on tick.
module dle_phase_tmr #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);

  logic [TO_W-1:0] cnt;
  logic [TO_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign expire  = tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (tick && !cnt_inc[TO_W]) cnt <= cnt_inc[TO_W-1:0];
  end

endmodule

// File: rtl/dline_err_chk.sv
module dline_err_chk
  import dle_pkg::*;
#(
  parameter int                 LEN_W    = 11,
  parameter int                 TO_W     = 16,
  parameter int                 CRC_W    = 16,
  parameter logic [CRC_W-1:0]   CRC_POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic [1:0]       xfer_mode,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [TO_W-1:0]  to_limit,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             err_crc,
  output logic             err_endbit,
  output logic             err_timeout
);

  localparam int CNT_W = LEN_W + 3;
  localparam int SH_W  = CRC_W - 1;

  dle_state_e       st, st_n;
  logic [CNT_W-1:0] bcnt, bcnt_val;
  logic             bcnt_ld, bcnt_dec, bcnt_zero;
  logic             crc_clr, crc_en, sh_en;
  logic             tmr_clr, tmr_tick, tmr_exp;
  logic             e_crc, e_end, e_to;
  logic [CRC_W-1:0] crc_calc;
  logic [SH_W-1:0]  sh_q;
  logic [CRC_W-1:0] crc_rx;
  logic             in_idle;

  assign bcnt_zero = (bcnt == '0);
  assign crc_rx    = {sh_q, bit_in};
  assign in_idle   = (st == S_IDLE);

  dle_crc_ser #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(bit_in), .crc(crc_calc)
  );

  dle_shreg #(.W(SH_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .en(sh_en), .din(bit_in), .q(sh_q)
  );

  dle_phase_tmr #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tmr_tick),
    .limit(to_limit), .expire(tmr_exp)
  );

  always_comb begin
    st_n     = st;
    e_crc    = 1'b0;
    e_end    = 1'b0;
    e_to     = 1'b0;
    tmr_clr  = 1'b0;
    tmr_tick = 1'b0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    sh_en    = 1'b0;
    bcnt_ld  = 1'b0;
    bcnt_dec = 1'b0;
    bcnt_val = '0;
    unique case (st)
      S_IDLE: begin
        if (xfer_start) begin
          tmr_clr = 1'b1;
          if (xfer_mode == XM_READ)       st_n = S_RD_WAIT;
          else if (xfer_mode == XM_WRITE) st_n = S_WR_WAIT;
          else if (xfer_mode == XM_BUSY)  st_n = S_BUSY;
        end
      end
      S_RD_WAIT: begin
        if (bit_vld) begin
          if (!bit_in) begin
            st_n     = S_RD_DATA;
            crc_clr  = 1'b1;
            bcnt_ld  = 1'b1;
            bcnt_val = {blk_len, 3'b000} - 1'b1;
          end else begin
            tmr_tick = 1'b1;
            if (tmr_exp) begin
              e_to = 1'b1;
              st_n = S_IDLE;
            end
          end
        end
      end
      S_RD_DATA: begin
        if (bit_vld) begin
          crc_en = 1'b1;
          if (bcnt_zero) begin
            st_n     = S_RD_CRC;
            bcnt_ld  = 1'b1;
            bcnt_val = CNT_W'(CRC_W - 1);
          end else begin
            bcnt_dec = 1'b1;
          end
        end
      end
      S_RD_CRC: begin
        if (bit_vld) begin
          sh_en = 1'b1;
          if (bcnt_zero) begin
            if (crc_rx != crc_calc) begin
              e_crc = 1'b1;
              st_n  = S_IDLE;
            end else begin
              st_n  = S_RD_END;
            end
          end else begin
            bcnt_dec = 1'b1;
          end
        end
      end
      S_RD_END: begin
        if (bit_vld) begin
          e_end = !bit_in;
          st_n  = S_IDLE;
        end
      end
      S_WR_WAIT: begin
        if (bit_vld) begin
          if (!bit_in) begin
            st_n     = S_WR_TOK;
            bcnt_ld  = 1'b1;
            bcnt_val = CNT_W'(TOK_W - 1);
          end else begin
            tmr_tick = 1'b1;
            if (tmr_exp) begin
              e_to = 1'b1;
              st_n = S_IDLE;
            end
          end
        end
      end
      S_WR_TOK: begin
        if (bit_vld) begin
          sh_en = 1'b1;
          if (bcnt_zero) st_n = S_WR_END;
          else           bcnt_dec = 1'b1;
        end
      end
      S_WR_END: begin
        if (bit_vld) begin
          if (!bit_in) begin
            e_end = 1'b1;
            st_n  = S_IDLE;
          end else if (sh_q[TOK_W-1:0] != TOK_GOOD) begin
            e_crc = 1'b1;
            st_n  = S_IDLE;
          end else begin
            tmr_clr = 1'b1;
            st_n    = S_BUSY;
          end
        end
      end
      S_BUSY: begin
        if (bit_vld) begin
          if (bit_in) begin
            st_n = S_IDLE;
          end else begin
            tmr_tick = 1'b1;
            if (tmr_exp) begin
              e_to = 1'b1;
              st_n = S_IDLE;
            end
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bcnt        <= '0;
      err_crc     <= 1'b0;
      err_endbit  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      st          <= st_n;
      err_crc     <= e_crc;
      err_endbit  <= e_end;
      err_timeout <= e_to;
      if (bcnt_ld)       bcnt <= bcnt_val;
      else if (bcnt_dec) bcnt <= bcnt - 1'b1;
    end
  end

endmodule

// File: rtl/dline_err_chk_chk.sv
module dline_err_chk_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic in_idle,
  input logic err_crc,
  input logic err_endbit,
  input logic err_timeout
);

  logic any_err;
  assign any_err = err_crc | err_endbit | err_timeout;

  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_crc, err_endbit, err_timeout})); // R13

  AST_CRC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |=> !err_crc); // R3

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_endbit |=> !err_endbit); // R13

  AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> !err_timeout); // R13

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> in_idle); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |=> !any_err); // R1

  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !any_err); // R13

endmodule

bind dline_err_chk dline_err_chk_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .bit_vld(bit_vld),
  .in_idle(in_idle),
  .err_crc(err_crc),
  .err_endbit(err_endbit),
  .err_timeout(err_timeout)
);

// File: tb/sim_dline_err_chk.sv
`timescale 1ns/1ps
module sim_dline_err_chk;

  localparam int LEN_W = 11;
  localparam int TO_W  = 16;
  localparam int LIM   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xfer_start = 1'b0;
  logic [1:0]       xfer_mode = 2'd0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [TO_W-1:0]  to_limit = TO_W'(LIM);
  logic             bit_vld = 1'b0;
  logic             bit_in = 1'b1;
  logic             err_crc, err_endbit, err_timeout;

  int checks = 0;
  int failures = 0;
  int n_crc = 0, n_end = 0, n_to = 0;
  int b_crc, b_end, b_to;

  always #2 clk = ~clk;

  dline_err_chk #(.LEN_W(LEN_W), .TO_W(TO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_mode(xfer_mode),
    .blk_len(blk_len), .to_limit(to_limit), .bit_vld(bit_vld), .bit_in(bit_in),
    .err_crc(err_crc), .err_endbit(err_endbit), .err_timeout(err_timeout)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      n_crc += int'(err_crc);
      n_end += int'(err_endbit);
      n_to  += int'(err_timeout);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic snap();
    b_crc = n_crc; b_end = n_end; b_to = n_to;
  endtask

  task automatic expect_counts(input int xc, input int xe, input int xt, input string req);
    repeat (4) @(negedge clk);
    chk((n_crc - b_crc) == xc, req, "crc pulses", n_crc - b_crc, xc);
    chk((n_end - b_end) == xe, req, "endbit pulses", n_end - b_end, xe);
    chk((n_to - b_to) == xt, req, "timeout pulses", n_to - b_to, xt);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
    bit_in  = 1'b1;
  endtask

  task automatic do_start(input logic [1:0] m);
    @(negedge clk);
    xfer_start = 1'b1;
    xfer_mode  = m;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 101 + 13) & 255);
  endfunction

  function automatic logic [15:0] ref_crc(input int len, input int seed);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      logic [7:0] by = pat(seed, i);
      for (int j = 7; j >= 0; j--) begin
        logic fb = by[j] ^ c[15];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic t_read(input int len, input int seed, input int pre,
                        input logic [15:0] flip, input logic endb,
                        input int xc, input int xe, input int xt, input string req);
    logic [15:0] c;
    snap();
    blk_len = LEN_W'(len);
    do_start(2'd0);
    for (int p = 0; p < pre; p++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < len; i++) begin
      logic [7:0] by = pat(seed, i);
      for (int j = 7; j >= 0; j--) send_bit(by[j]);
    end
    c = ref_crc(len, seed) ^ flip;
    for (int k = 15; k >= 0; k--) begin
      send_bit(c[k]);
      if (k == 0 && xc == 1) begin
        chk(err_crc === 1'b1, "R3", "crc pulse after last crc bit", int'(err_crc), 1);
        @(negedge clk);
        chk(err_crc === 1'b0, "R13", "crc pulse one cycle wide", int'(err_crc), 0);
      end
    end
    send_bit(endb);
    expect_counts(xc, xe, xt, req);
  endtask

  task automatic t_write(input int pre, input logic [2:0] tok, input logic endb,
                         input int busy, input int xc, input int xe, input int xt,
                         input string req);
    snap();
    do_start(2'd1);
    for (int p = 0; p < pre; p++) send_bit(1'b1);
    send_bit(1'b0);
    for (int k = 2; k >= 0; k--) send_bit(tok[k]);
    send_bit(endb);
    for (int q = 0; q < busy; q++) send_bit(1'b0);
    send_bit(1'b1);
    expect_counts(xc, xe, xt, req);
  endtask

  task automatic t_reset();
    chk(err_crc === 1'b0, "R1", "err_crc at reset", int'(err_crc), 0);
    chk(err_endbit === 1'b0, "R1", "err_endbit at reset", int'(err_endbit), 0);
    chk(err_timeout === 1'b0, "R1", "err_timeout at reset", int'(err_timeout), 0);
    snap();
    for (int i = 0; i < 12; i++) send_bit(1'(i % 3 == 0));
    expect_counts(0, 0, 0, "R1");
  endtask

  task automatic t_rd_timeout();
    snap();
    blk_len = LEN_W'(2);
    do_start(2'd0);
    for (int p = 0; p < LIM; p++) send_bit(1'b1);
    expect_counts(0, 0, 1, "R8");
    snap();
    send_bit(1'b0);
    for (int i = 0; i < 40; i++) send_bit(1'b0);
    expect_counts(0, 0, 0, "R12");
  endtask

  task automatic t_wr_timeout();
    snap();
    do_start(2'd1);
    for (int p = 0; p < LIM; p++) send_bit(1'b1);
    expect_counts(0, 0, 1, "R9");
  endtask

  task automatic t_busy_only();
    snap();
    do_start(2'd2);
    for (int q = 0; q < LIM - 1; q++) send_bit(1'b0);
    send_bit(1'b1);
    expect_counts(0, 0, 0, "R11");
    snap();
    do_start(2'd2);
    for (int q = 0; q < LIM; q++) send_bit(1'b0);
    expect_counts(0, 0, 1, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(1, 5, 0, 16'h0000, 1'b1, 0, 0, 0, "R2");
    t_read(4, 9, LIM - 1, 16'h0000, 1'b1, 0, 0, 0, "R2");
    t_read(3, 2, 1, 16'h0001, 1'b0, 1, 0, 0, "R3");
    t_read(2, 7, 2, 16'h8000, 1'b1, 1, 0, 0, "R3");
    t_read(2, 11, 0, 16'h0000, 1'b0, 0, 1, 0, "R4");
    t_write(LIM - 1, 3'b010, 1'b1, LIM - 1, 0, 0, 0, "R7");
    t_write(0, 3'b101, 1'b1, 2, 1, 0, 0, "R5");
    t_write(1, 3'b011, 1'b1, 0, 1, 0, 0, "R5");
    t_write(0, 3'b010, 1'b0, 2, 0, 1, 0, "R6");
    t_write(0, 3'b110, 1'b0, 0, 0, 1, 0, "R6");
    t_write(2, 3'b010, 1'b1, LIM, 0, 0, 1, "R10");
    t_rd_timeout();
    t_wr_timeout();
    t_busy_only();
    t_read(1, 3, 0, 16'h0000, 1'b1, 0, 0, 0, "R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule